// File: doc/BRIEF.md
# Halting Fetch-Step Sequencer

This block drives a simple 32-bit core through its instruction steps, one instruction at a time. Each instruction is read as four separate byte reads from a byte-wide memory port, beginning at the current program counter. The four bytes are joined into one word, least significant byte first. After a single decode cycle the word goes to an external execute unit. That unit holds the register file and ALU, and it returns the address of the following instruction. That address is staged in a register and moved into the program counter in a separate commit cycle. So the program counter changes only after execution has finished.

A run starts with a one-cycle request that carries an instruction count N. Before each instruction the sequencer looks at an external halt flag. If the flag is set, or if N instructions have already completed, the run ends and a one-cycle done pulse is given. The program counter is kept from one run to the next. It returns to a parameter value only on reset.

The state machine has six states. IDLE waits for a request; a request loads the count and moves to CHECK. CHECK ends the run and returns to IDLE if halt is set or the count is used up; otherwise it moves to FETCH. FETCH issues four byte reads and moves to DECODE when the fourth byte is accepted. DECODE moves to EXEC after one cycle. EXEC moves to COMMIT when the execute unit accepts. COMMIT loads the program counter, reduces the count and returns to CHECK.

Top module: `step_sequencer`

## Requirements
- R1: Out of reset, pc equals the RESET_PC parameter, and busy, done, mem_req_valid and exec_valid are all low.
- R2: Each instruction follows a fixed order: four accepted byte reads, then exactly one idle decode cycle, then exec_valid, then a commit cycle. exec_valid is first seen two cycles after the cycle in which the fourth byte is accepted. mem_req_valid, exec_valid and done are never high together.
- R3: The byte reads of one instruction go to pc, pc+1, pc+2 and pc+3, in that order.
- R4: The byte read at pc becomes exec_insn[7:0]. The bytes at pc+1, pc+2 and pc+3 become bits [15:8], [23:16] and [31:24].
- R5: pc does not change during fetch, decode or execute, and exec_pc equals pc while exec_valid is high.
- R6: The exec_next_pc value present in the cycle when exec_ready is accepted becomes pc two cycles later. Later changes on exec_next_pc have no effect on it.
- R7: With halt low, a run with count N executes exactly N instructions. N = 0 executes none.
- R8: halt_flag is sampled before each instruction. If it is high, no further byte read is issued and the run ends. A flag already set when the run starts gives zero fetches.
- R9: done is high for exactly one cycle per run, at the point where the run ends. busy is high from the cycle after the request until done.
- R10: run_req and run_count are ignored while busy is high.
- R11: While mem_ready is low, mem_req_valid stays high and mem_req_addr stays unchanged. The byte is taken only in a cycle with mem_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_req | input | 1 | One-cycle start request, taken in IDLE |
| run_count | input | CNT_W | Number of instructions to run |
| halt_flag | input | 1 | Stop request, sampled before each instruction |
| mem_req_valid | output | 1 | Byte read request |
| mem_req_addr | output | AW | Byte address of the read |
| mem_ready | input | 1 | Read accepted; mem_rdata is valid |
| mem_rdata | input | 8 | Returned byte |
| exec_valid | output | 1 | Instruction offered to the execute unit |
| exec_insn | output | 32 | Assembled instruction word |
| exec_pc | output | AW | Address of the offered instruction |
| exec_ready | input | 1 | Execute unit accepts; exec_next_pc is valid |
| exec_next_pc | input | AW | Address of the following instruction |
| pc | output | AW | Architectural program counter |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench sweeps every count from 0 to 8 against every halt point. A halt point can be before the first instruction, after each instruction in turn, or never. This separates count exhaustion from halting, including the case where both happen at the same boundary. Memory latency depends on the address and execute latency depends on the instruction. This tests whether bytes are taken only with ready and whether the address is held while waiting. The execute model sometimes returns non-sequential next addresses, and it drives unrelated values on exec_next_pc after acceptance. This shows whether the staged value or the live input reaches pc. A second request is also issued during every non-empty run, to show that it is ignored while busy.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int unsigned INSN_W = 32;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_COMMIT
    } seq_state_e;
endpackage

// File: rtl/insn_assembler.sv
module insn_assembler #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned LANE_W = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    clear,
    input  logic                                    take,
    input  logic [LANE_W-1:0]                       lane_in,
    output logic [WORD_W-1:0]                       word,
    output logic [$clog2(WORD_W/LANE_W)-1:0]        lane_idx,
    output logic                                    last_lane
);
    localparam int unsigned LANES = WORD_W / LANE_W;
    localparam int unsigned IDX_W = $clog2(LANES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lane_idx <= '0;
        end else if (take) begin
            lane_idx <= lane_idx + 1'b1;
        end
    end

    assign last_lane = (lane_idx == LAST_IDX);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (take && (lane_idx == IDX_W'(g))) begin
                lane_q <= lane_in;
            end
        end
        assign word[g*LANE_W +: LANE_W] = lane_q;
    end

    AST_LANE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (lane_idx == '0)); // R3
endmodule

// File: rtl/step_counter.sv
module step_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (dec) begin
            remaining <= remaining - 1'b1;
        end
    end

    assign zero = (remaining == '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !zero); // R7
endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
    import seq_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned CNT_W    = 16,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic [CNT_W-1:0]  run_count,
    input  logic              halt_flag,
    output logic              mem_req_valid,
    output logic [AW-1:0]     mem_req_addr,
    input  logic              mem_ready,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              exec_valid,
    output logic [INSN_W-1:0] exec_insn,
    output logic [AW-1:0]     exec_pc,
    input  logic              exec_ready,
    input  logic [AW-1:0]     exec_next_pc,
    output logic [AW-1:0]     pc,
    output logic              busy,
    output logic              done
);
    localparam int unsigned IDX_W = $clog2(INSN_W / BYTE_W);

    seq_state_e state, state_nx;
    logic [AW-1:0]    staged_pc;
    logic [IDX_W-1:0] lane_idx;
    logic             last_lane;
    logic             count_zero;
    logic             run_end;

    assign run_end = halt_flag || count_zero;

    insn_assembler #(.WORD_W(INSN_W), .LANE_W(BYTE_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state == ST_CHECK),
        .take      ((state == ST_FETCH) && mem_ready),
        .lane_in   (mem_rdata),
        .word      (exec_insn),
        .lane_idx  (lane_idx),
        .last_lane (last_lane)
    );

    step_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     ((state == ST_IDLE) && run_req),
        .load_val (run_count),
        .dec      (state == ST_COMMIT),
        .zero     (count_zero)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (run_req) state_nx = ST_CHECK;
            ST_CHECK:  state_nx = run_end ? ST_IDLE : ST_FETCH;
            ST_FETCH:  if (mem_ready && last_lane) state_nx = ST_DECODE;
            ST_DECODE: state_nx = ST_EXEC;
            ST_EXEC:   if (exec_ready) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_CHECK;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc        <= RESET_PC;
            staged_pc <= RESET_PC;
        end else begin
            if ((state == ST_EXEC) && exec_ready) staged_pc <= exec_next_pc;
            if (state == ST_COMMIT) pc <= staged_pc;
        end
    end

    always_comb begin
        mem_req_valid = (state == ST_FETCH);
        mem_req_addr  = pc + AW'(lane_idx);
        exec_valid    = (state == ST_EXEC);
        exec_pc       = pc;
        busy          = (state != ST_IDLE);
        done          = (state == ST_CHECK) && run_end;
    end

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COMMIT) |=> $stable(pc)); // R5
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11
    AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && !exec_ready) |=> (exec_valid && $stable(exec_insn))); // R2
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_valid, exec_valid, done})); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_HALT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!mem_req_valid && !busy)); // R8
endmodule

// File: tb/step_sequencer_bench.sv
module step_sequencer_bench;
    localparam logic [31:0] START_PC = 32'h0000_0024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_req = 1'b0;
    logic [15:0] run_count = '0;
    logic        halt_flag = 1'b0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_ready = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        exec_valid;
    logic [31:0] exec_insn;
    logic [31:0] exec_pc;
    logic        exec_ready = 1'b0;
    logic [31:0] exec_next_pc = '0;
    logic [31:0] pc;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_cnt = 0;
    int exec_cnt = 0;
    int byte_total = 0;
    int byte_k = 0;
    int gap = 100;
    int mwait = 0;
    int ewait = 0;
    int halt_at = 1000;
    bit exec_seen = 1'b0;
    logic [31:0] cur_pc = START_PC;

    always #5 clk = ~clk;

    step_sequencer #(.AW(32), .CNT_W(16), .RESET_PC(START_PC)) u_step_sequencer (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .run_count(run_count),
        .halt_flag(halt_flag), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .exec_valid(exec_valid),
        .exec_insn(exec_insn), .exec_pc(exec_pc), .exec_ready(exec_ready),
        .exec_next_pc(exec_next_pc), .pc(pc), .busy(busy), .done(done)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        logic [7:0] m;
        m = 8'(a[7:0] * 8'd29);
        return m ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] p);
        return {mem_byte(p + 32'd3), mem_byte(p + 32'd2), mem_byte(p + 32'd1), mem_byte(p)};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor and responders: sample outputs first, then drive inputs.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_sim();
        end
        if (gap < 100) gap++;
        if (rst_n) begin
            if (done) done_cnt++;
            if (mem_req_valid) begin
                check("R2", "no exec during fetch", {31'd0, exec_valid}, 32'd0);
                check("R9", "busy during fetch", {31'd0, busy}, 32'd1);
                check("R5", "pc during fetch", pc, cur_pc);
                check("R3", "byte address", mem_req_addr, cur_pc + 32'(byte_k));
                if (mwait >= int'(mem_req_addr[1:0] ^ mem_req_addr[3:2])) begin
                    mem_ready = 1'b1;
                    mem_rdata = mem_byte(mem_req_addr);
                    mwait = 0;
                    byte_k++;
                    byte_total++;
                    if (byte_k == 4) gap = 0;
                end else begin
                    mem_ready = 1'b0;
                    mem_rdata = ~mem_byte(mem_req_addr);  // R11: data without ready must be ignored
                    mwait++;
                end
            end else begin
                mem_ready = 1'b0;
                mem_rdata = 8'hC3;
            end
            if (exec_valid) begin
                if (!exec_seen) begin
                    exec_seen = 1'b1;
                    check("R2", "decode gap", 32'(gap), 32'd2);
                    check("R2", "bytes before exec", 32'(byte_k), 32'd4);
                    check("R4", "assembled word", exec_insn, word_at(cur_pc));
                    check("R5", "exec_pc", exec_pc, cur_pc);
                end
                check("R5", "pc during exec", pc, cur_pc);
                if (ewait >= int'(exec_insn[5:4])) begin
                    logic [31:0] npc;
                    npc = exec_insn[3] ? cur_pc + {22'd0, exec_insn[9:4], 2'b00} + 32'd4
                                       : cur_pc + 32'd4;
                    exec_ready = 1'b1;
                    exec_next_pc = npc;
                    cur_pc = npc;
                    ewait = 0;
                    byte_k = 0;
                    exec_seen = 1'b0;
                    exec_cnt++;
                    if (exec_cnt == halt_at) halt_flag = 1'b1;
                end else begin
                    exec_ready = 1'b0;
                    exec_next_pc = 32'hDEAD_BEE0;
                    ewait++;
                end
            end else begin
                exec_ready = 1'b0;
                exec_next_pc = 32'hBAD0_0000 ^ 32'(cyc);   // R6: live value after accept must not reach pc
            end
        end
    end

    task automatic run_case(input int n, input int h);
        int exp_exec;
        exp_exec = (h < n) ? h : n;
        @(negedge clk);
        done_cnt = 0;
        exec_cnt = 0;
        byte_total = 0;
        halt_at = h;
        halt_flag = (h == 0);
        run_count = 16'(n);
        run_req = 1'b1;
        @(negedge clk);
        run_req = 1'b0;
        if (exp_exec >= 1) begin
            repeat (3) @(negedge clk);
            run_count = 16'd15;
            run_req = 1'b1;   // R10: must be ignored while busy
            @(negedge clk);
            run_req = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R9", "done pulses", 32'(done_cnt), 32'd1);
        check("R9", "busy after run", {31'd0, busy}, 32'd0);
        if (h <= n) check("R8", "execs with halt", 32'(exec_cnt), 32'(exp_exec));
        else        check("R7", "execs without halt", 32'(exec_cnt), 32'(exp_exec));
        if (exp_exec >= 1) check("R10", "execs despite second request", 32'(exec_cnt), 32'(exp_exec));
        check("R8", "bytes fetched", 32'(byte_total), 32'(4 * exp_exec));
        check("R6", "pc after run", pc, cur_pc);
        halt_flag = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset pc", pc, START_PC);
        check("R1", "reset busy", {31'd0, busy}, 32'd0);
        check("R1", "reset done", {31'd0, done}, 32'd0);
        check("R1", "reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
        check("R1", "reset exec_valid", {31'd0, exec_valid}, 32'd0);
        for (int n = 0; n <= 8; n++) begin
            for (int h = 0; h <= n + 1; h++) begin
                run_case(n, h);
            end
        end
        run_case(40, 1000);
        finish_sim();
    end
endmodule